// File: doc/BRIEF.md
# Serial EEPROM command front-end

This block is the slave side of a word-organised serial EEPROM: 128 words of 16 bits, held in a register file. All of its pins are sampled on the system clock. After chip-select rises, the block looks for a start bit on the serial data input. It then shifts in a 2-bit opcode and an 8-bit address field. It decodes read, single-word write, four-word page write, write-all, write-enable and write-disable. A read sends one dummy zero and then the addressed word on the serial output. A write is held until chip-select falls, and it commits only if the bit count is exact and every guard allows it.

Address protection is decided outside the block. The block shows the address that a pending write would touch on `chk_addr_o`, and an external protection unit answers on `wr_allowed_i`. A second input, `prot_clear_i`, reports that the protection register is in its cleared state. When the protect-select pin is high, the front-end does not act on the instruction at all. The protect-register commands belong to another unit.

Top module: `eep_front`

## Requirements
- R1: While chip-select is high and no instruction has started, every serial-clock rising edge that samples a 0 is discarded. The first 1 sampled is the start bit.
- R2: After the start bit, the block shifts in 10 bits MSB first: the opcode (2 bits), then the address field (8 bits). Address field bit 7 is ignored, so addresses 0x03 and 0x83 select the same word.
- R3: A read loads the output on the rising edge that samples address bit 0, and `do_o` shows a dummy 0 there. Each of the next 16 rising edges moves the output to the next bit of the word, MSB first.
- R4: `do_oe_o` is high only while chip-select is high and a read has passed its last address bit. It is low in the cycle after chip-select goes low.
- R5: Reset clears the write-enable latch, abandons any instruction in progress, disables the output and sets all words to zero.
- R6: With protect-select low, the opcodes decode as 10 = read, 01 = write, 11 = page write. For opcode 00, address bits [7:6] select the command: 01 = write-all, 11 = write-enable, 00 = write-disable, 10 = no action.
- R7: Write-enable sets the latch only when `wc_i` is high at the last address bit. Write, page write and write-all commit only when `wc_i` is high at the fall of chip-select. Read and write-disable act whatever the level of `wc_i`.
- R8: A single-word write commits at the fall of chip-select. It needs exactly 16 data bits, the latch set and `wr_allowed_i` high. Any other case leaves memory unchanged.
- R9: A page write writes 4 words starting at the address aligned down to a multiple of 4, first word received to the lowest address. It needs exactly 64 data bits. It is rejected as a whole unless `wr_allowed_i` is high for the highest word of the page.
- R10: Write-all takes exactly 16 data bits and writes them to every word. It also needs the latch set, `wc_i` high and `prot_clear_i` high at the fall of chip-select.
- R11: With `psel_i` high at the last address bit, the instruction is ignored: no output, no write and no change to the latch.
- R12: While a write is pending, `chk_addr_o` shows its target word. For a page write this is the highest word of the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all pins are sampled on it |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock; its rising edges are detected |
| di_i | input | 1 | Serial data in |
| wc_i | input | 1 | Write control; must be high for state-changing writes |
| psel_i | input | 1 | Protect select; high hands the instruction to the protection unit |
| wr_allowed_i | input | 1 | External protection verdict for `chk_addr_o` |
| prot_clear_i | input | 1 | Protection register is in its cleared state |
| chk_addr_o | output | 7 | Word address submitted for the protection check |
| do_o | output | 1 | Serial data out |
| do_oe_o | output | 1 | Output enable for `do_o` |

## Verification
On every cycle, the assertions check the guards that apply to any commit. A commit happens only on a chip-select fall, only with write control high and the latch set, and at most one kind of write at a time. A single or page write needs the protection verdict, and write-all needs the cleared flag. They also check that the latch never rises without write control, that the output enable follows chip-select, and that the first bit driven is the dummy zero. Only the bench scenarios can show the results of a command: the start-bit hunt, bit-7 aliasing, the exact data-bit count, page alignment and whole-page rejection, and the word order of read data.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int OP_W     = 2;
  localparam int AFIELD_W = 8;
  localparam int HDR_W    = OP_W + AFIELD_W;

  typedef enum logic [2:0] {
    PH_IDLE, PH_HUNT, PH_HDR, PH_DATA, PH_READ, PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {
    OP_SPECIAL = 2'b00,
    OP_WRITE   = 2'b01,
    OP_READ    = 2'b10,
    OP_PAGE    = 2'b11
  } op_e;

  // sub-command in address bits [7:6] when opcode is 00
  localparam logic [1:0] SUB_WDS   = 2'b00;
  localparam logic [1:0] SUB_WRALL = 2'b01;
  localparam logic [1:0] SUB_WEN   = 2'b11;
endpackage

// File: rtl/eep_edge.sv
module eep_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_i,
  output logic sck_rise_o,
  output logic cs_fall_o
);
  logic sck_q, cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_i;
    end
  end

  assign sck_rise_o = sck_i & ~sck_q;
  assign cs_fall_o  = ~cs_i & cs_q;
endmodule

// File: rtl/eep_cmd.sv
module eep_cmd
  import eep_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 7,
  parameter int PAGE_WORDS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cs_i,
  input  logic                          di_i,
  input  logic                          sck_rise_i,
  input  logic                          cs_fall_i,
  input  logic                          wc_i,
  input  logic                          psel_i,
  input  logic                          wr_allowed_i,
  input  logic                          prot_clear_i,
  output logic                          rd_load_o,
  output logic [ADDR_W-1:0]             rd_addr_o,
  output logic                          wr_word_o,
  output logic                          wr_page_o,
  output logic                          wr_all_o,
  output logic [ADDR_W-1:0]             wr_addr_o,
  output logic [WORD_W*PAGE_WORDS-1:0]  wr_data_o,
  output logic [ADDR_W-1:0]             chk_addr_o,
  output logic                          wel_o
);
  localparam int PAGE_BITS = WORD_W * PAGE_WORDS;
  localparam int PAGE_LOG  = $clog2(PAGE_WORDS);
  localparam int HCNT_W    = $clog2(HDR_W);
  localparam int DCNT_W    = $clog2(PAGE_BITS) + 2;

  phase_e               phase_q;
  logic [HDR_W-2:0]     hdr_q;
  logic [HCNT_W-1:0]    hcnt_q;
  op_e                  op_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [PAGE_BITS-1:0] data_q;
  logic [DCNT_W-1:0]    dcnt_q;
  logic                 wel_q;

  logic [HDR_W-1:0]     hdr_full;
  op_e                  op_n;
  logic [1:0]           sub_n;
  logic                 last_hdr, pend;
  logic [ADDR_W-1:0]    pg_base;

  assign hdr_full = {hdr_q, di_i};
  assign op_n     = op_e'(hdr_full[HDR_W-1 -: OP_W]);
  assign sub_n    = hdr_full[AFIELD_W-1 -: 2];
  assign last_hdr = (phase_q == PH_HDR) && sck_rise_i && (hcnt_q == HCNT_W'(HDR_W-1));

  assign rd_load_o = last_hdr && !psel_i && (op_n == OP_READ);
  assign rd_addr_o = hdr_full[ADDR_W-1:0];

  assign pg_base    = {addr_q[ADDR_W-1:PAGE_LOG], {PAGE_LOG{1'b0}}};
  // protected area lies above a boundary, so the top word of a page decides
  assign chk_addr_o = (op_q == OP_PAGE) ? (pg_base | ADDR_W'(PAGE_WORDS-1)) : addr_q;

  assign pend      = (phase_q == PH_DATA) && cs_fall_i && wel_q && wc_i;
  assign wr_word_o = pend && (op_q == OP_WRITE)   && (dcnt_q == DCNT_W'(WORD_W))    && wr_allowed_i;
  assign wr_page_o = pend && (op_q == OP_PAGE)    && (dcnt_q == DCNT_W'(PAGE_BITS)) && wr_allowed_i;
  assign wr_all_o  = pend && (op_q == OP_SPECIAL) && (dcnt_q == DCNT_W'(WORD_W))    && prot_clear_i;
  assign wr_addr_o = (op_q == OP_PAGE) ? pg_base : addr_q;
  assign wr_data_o = data_q;
  assign wel_o     = wel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      hdr_q   <= '0;
      hcnt_q  <= '0;
      op_q    <= OP_SPECIAL;
      addr_q  <= '0;
      data_q  <= '0;
      dcnt_q  <= '0;
      wel_q   <= 1'b0;
    end else if (!cs_i) begin
      phase_q <= PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: phase_q <= PH_HUNT;
        PH_HUNT: if (sck_rise_i && di_i) begin
          phase_q <= PH_HDR;
          hcnt_q  <= '0;
        end
        PH_HDR: if (sck_rise_i) begin
          hdr_q  <= hdr_full[HDR_W-2:0];
          hcnt_q <= hcnt_q + 1'b1;
          if (last_hdr) begin
            op_q   <= op_n;
            addr_q <= hdr_full[ADDR_W-1:0];
            dcnt_q <= '0;
            if (psel_i) phase_q <= PH_SKIP;
            else begin
              unique case (op_n)
                OP_READ:           phase_q <= PH_READ;
                OP_WRITE, OP_PAGE: phase_q <= PH_DATA;
                OP_SPECIAL: begin
                  phase_q <= (sub_n == SUB_WRALL) ? PH_DATA : PH_SKIP;
                  if (sub_n == SUB_WEN && wc_i) wel_q <= 1'b1;
                  if (sub_n == SUB_WDS)         wel_q <= 1'b0;
                end
              endcase
            end
          end
        end
        PH_DATA: if (sck_rise_i) begin
          data_q <= {data_q[PAGE_BITS-2:0], di_i};
          if (dcnt_q != '1) dcnt_q <= dcnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 7,
  parameter int PAGE_WORDS = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_word_i,
  input  logic                          wr_page_i,
  input  logic                          wr_all_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [WORD_W*PAGE_WORDS-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [WORD_W-1:0]             rd_data_o
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PAGE_BITS = WORD_W * PAGE_WORDS;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_all_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= wr_data_i[WORD_W-1:0];
    end else if (wr_word_i) begin
      mem_q[wr_addr_i] <= wr_data_i[WORD_W-1:0];
    end else if (wr_page_i) begin
      for (int k = 0; k < PAGE_WORDS; k++)
        mem_q[wr_addr_i + ADDR_W'(k)] <= wr_data_i[PAGE_BITS-1-k*WORD_W -: WORD_W];
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/eep_dout.sv
module eep_dout #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sck_rise_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              do_o,
  output logic              oe_o
);
  logic [WORD_W:0] sh_q;
  logic            act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (!cs_i) begin
      act_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= {1'b0, word_i};  // leading dummy zero
      act_q <= 1'b1;
    end else if (act_q && sck_rise_i) begin
      sh_q  <= {sh_q[WORD_W-1:0], 1'b0};
    end
  end

  assign do_o = act_q & sh_q[WORD_W];
  assign oe_o = act_q & cs_i;
endmodule

// File: rtl/eep_front.sv
module eep_front #(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 7,
  parameter int PAGE_WORDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sck_i,
  input  logic              di_i,
  input  logic              wc_i,
  input  logic              psel_i,
  input  logic              wr_allowed_i,
  input  logic              prot_clear_i,
  output logic [ADDR_W-1:0] chk_addr_o,
  output logic              do_o,
  output logic              do_oe_o
);
  localparam int PAGE_BITS = WORD_W * PAGE_WORDS;

  logic                 sck_rise, cs_fall;
  logic                 rd_load, wr_word, wr_page, wr_all, wel;
  logic [ADDR_W-1:0]    rd_addr, wr_addr;
  logic [PAGE_BITS-1:0] wr_data;
  logic [WORD_W-1:0]    rd_data;

  eep_edge u_edge (
    .clk_i, .rst_ni, .sck_i, .cs_i,
    .sck_rise_o (sck_rise),
    .cs_fall_o  (cs_fall)
  );

  eep_cmd #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) u_cmd (
    .clk_i, .rst_ni, .cs_i, .di_i,
    .sck_rise_i   (sck_rise),
    .cs_fall_i    (cs_fall),
    .wc_i, .psel_i, .wr_allowed_i, .prot_clear_i,
    .rd_load_o    (rd_load),
    .rd_addr_o    (rd_addr),
    .wr_word_o    (wr_word),
    .wr_page_o    (wr_page),
    .wr_all_o     (wr_all),
    .wr_addr_o    (wr_addr),
    .wr_data_o    (wr_data),
    .chk_addr_o   (chk_addr_o),
    .wel_o        (wel)
  );

  eep_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) u_array (
    .clk_i, .rst_ni,
    .wr_word_i (wr_word),
    .wr_page_i (wr_page),
    .wr_all_i  (wr_all),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  eep_dout #(.WORD_W(WORD_W)) u_dout (
    .clk_i, .rst_ni, .cs_i,
    .sck_rise_i (sck_rise),
    .load_i     (rd_load),
    .word_i     (rd_data),
    .do_o       (do_o),
    .oe_o       (do_oe_o)
  );
endmodule

// File: rtl/eep_front_chk.sv
module eep_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_i,
  input logic wc_i,
  input logic psel_i,
  input logic wr_allowed_i,
  input logic prot_clear_i,
  input logic do_o,
  input logic do_oe_o,
  input logic wel,
  input logic wr_word,
  input logic wr_page,
  input logic wr_all
);
  logic wr_any;
  assign wr_any = wr_word | wr_page | wr_all;

  a_r4_oe_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    do_oe_o |-> cs_i);

  a_r4_oe_drops_after_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !do_oe_o);

  a_r3_dummy_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(do_oe_o) |-> !do_o);

  a_r8_commit_on_cs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |-> (!cs_i && $past(cs_i)));

  a_r8_commit_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |-> wel);

  a_r7_commit_needs_wc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |-> wc_i);

  a_r9_one_write_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_word, wr_page, wr_all}));

  a_r9_write_needs_allowed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_word | wr_page) |-> wr_allowed_i);

  a_r10_wrall_needs_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_all |-> prot_clear_i);

  a_r11_wel_rise_guarded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel) |-> $past(wc_i && !psel_i));
endmodule

bind eep_front eep_front_chk u_chk (
  .clk_i, .rst_ni, .cs_i, .wc_i, .psel_i, .wr_allowed_i, .prot_clear_i,
  .do_o, .do_oe_o,
  .wel     (wel),
  .wr_word (wr_word),
  .wr_page (wr_page),
  .wr_all  (wr_all)
);

// File: tb/eep_front_tb.sv
`timescale 1ns/1ps
module eep_front_tb;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs = 0, sck = 0, di = 0, wc = 1, psel = 0, pclr = 0;
  logic [7:0] bound = 8'd128;
  logic wr_allowed;
  logic [6:0] chk_addr;
  logic do_o, do_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] mem_m [128];
  bit wel_m = 0;

  always #2.5 clk = ~clk;

  assign wr_allowed = ({1'b0, chk_addr} < bound);

  eep_front u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .sck_i(sck), .di_i(di),
    .wc_i(wc), .psel_i(psel), .wr_allowed_i(wr_allowed), .prot_clear_i(pclr),
    .chk_addr_o(chk_addr), .do_o(do_o), .do_oe_o(do_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic sck_bit(input logic b);
    @(negedge clk); di = b; sck = 1'b1;
    repeat (2) @(negedge clk); sck = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk); cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk); cs = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_hdr(input int lead, input logic [1:0] op, input logic [7:0] a);
    cs_on();
    repeat (lead) sck_bit(1'b0);
    sck_bit(1'b1);
    sck_bit(op[1]); sck_bit(op[0]);
    for (int i = 7; i >= 0; i--) sck_bit(a[i]);
  endtask

  // reference model of one non-read command
  task automatic model_cmd(input logic [1:0] op, input logic [7:0] a, input int nbits, input logic [63:0] d);
    logic [6:0] base;
    if (psel) return;
    base = a[6:0] & 7'h7C;
    case (op)
      2'b00: case (a[7:6])
        2'b11: if (wc) wel_m = 1;
        2'b00: wel_m = 0;
        2'b01: if (nbits == 16 && wel_m && wc && pclr)
                 for (int i = 0; i < 128; i++) mem_m[i] = d[15:0];
        default: ;
      endcase
      2'b01: if (nbits == 16 && wel_m && wc && ({1'b0, a[6:0]} < bound)) mem_m[a[6:0]] = d[15:0];
      2'b11: if (nbits == 64 && wel_m && wc && ({1'b0, base} + 8'd3 < bound))
               for (int k = 0; k < 4; k++) mem_m[base + 7'(k)] = d[63-16*k -: 16];
      default: ;
    endcase
  endtask

  task automatic xfer(input logic [1:0] op, input logic [7:0] a, input int nbits, input logic [63:0] d, input int lead);
    send_hdr(lead, op, a);
    for (int i = nbits - 1; i >= 0; i--) sck_bit(d[i]);
    cs_off();
    model_cmd(op, a, nbits, d);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string req, input int lead);
    logic [15:0] got;
    send_hdr(lead, 2'b10, a);
    if (psel) chk(do_oe == 1'b0, "R11 read ignored", 64'(do_oe), 64'd0);
    else chk(do_oe && !do_o, "R3 dummy zero", 64'({do_oe, do_o}), 64'h2);
    for (int i = 15; i >= 0; i--) begin
      sck_bit(1'b0);
      got[i] = do_o;
    end
    if (!psel) chk(got == mem_m[a[6:0]], req, 64'(got), 64'(mem_m[a[6:0]]));
    cs_off();
    chk(!do_oe, "R4 oe off after cs", 64'(do_oe), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int kind, nb;
    logic [7:0] a;
    logic [63:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) mem_m[i] = '0;
    repeat (4) @(negedge clk);
    chk(do_oe == 1'b0, "R5 oe in reset", 64'(do_oe), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R5: array clear, latch clear
    rd_chk(8'h05, "R5 reset word zero", 0);
    xfer(2'b01, 8'h03, 16, 64'h1234, 0);
    rd_chk(8'h03, "R5 R8 write without latch ignored", 0);

    // R7: enable needs wc
    wc = 0; xfer(2'b00, 8'hC0, 0, 0, 0); wc = 1;
    xfer(2'b01, 8'h03, 16, 64'h1234, 0);
    rd_chk(8'h03, "R7 enable with wc low", 0);

    // R11: protect-select high ignores the command
    psel = 1; xfer(2'b00, 8'hC0, 0, 0, 0); rd_chk(8'h03, "R11", 0); psel = 0;
    xfer(2'b01, 8'h03, 16, 64'h1234, 0);
    rd_chk(8'h03, "R11 enable ignored", 0);

    // R1: leading zeros before the start bit
    xfer(2'b00, 8'hC0, 0, 0, 3);
    xfer(2'b01, 8'h03, 16, 64'hA5C3, 5);
    rd_chk(8'h03, "R1 R8 write after hunt", 2);
    rd_chk(8'h83, "R2 bit7 alias", 0);

    // R8: exact bit count
    xfer(2'b01, 8'h04, 15, 64'h7FFF, 0);
    rd_chk(8'h04, "R8 short write", 0);
    xfer(2'b01, 8'h04, 17, 64'h1FFFF, 0);
    rd_chk(8'h04, "R8 long write", 0);

    // R7: write needs wc at cs fall
    wc = 0; xfer(2'b01, 8'h06, 16, 64'hBEEF, 0); wc = 1;
    rd_chk(8'h06, "R7 write wc low", 0);

    // R12/R8: protection check address
    bound = 8'd40;
    send_hdr(0, 2'b01, 8'h32);
    chk(chk_addr == 7'h32, "R12 word check addr", 64'(chk_addr), 64'h32);
    for (int i = 15; i >= 0; i--) sck_bit(1'b1);
    cs_off(); model_cmd(2'b01, 8'h32, 16, 64'hFFFF);
    rd_chk(8'h32, "R8 protected write", 0);

    send_hdr(0, 2'b11, 8'h25);
    chk(chk_addr == 7'd39, "R12 page check addr", 64'(chk_addr), 64'd39);
    d = 64'h1111_2222_3333_4444;
    for (int i = 63; i >= 0; i--) sck_bit(d[i]);
    cs_off(); model_cmd(2'b11, 8'h25, 64, d);
    for (int k = 36; k < 40; k++) rd_chk(8'(k), "R9 page aligned", 0);
    rd_chk(8'd35, "R9 below page", 0);

    bound = 8'd38;
    xfer(2'b11, 8'h26, 64, 64'hAAAA_BBBB_CCCC_DDDD, 0);
    rd_chk(8'd36, "R9 page rejected whole", 0);
    rd_chk(8'd37, "R9 page rejected whole", 0);
    bound = 8'd128;

    // R10: write-all gated by cleared flag
    pclr = 0; xfer(2'b00, 8'h40, 16, 64'h5A5A, 0);
    rd_chk(8'h10, "R10 wrall blocked", 0);
    pclr = 1; xfer(2'b00, 8'h40, 16, 64'h5A5A, 0);
    rd_chk(8'h10, "R10 wrall", 0);
    rd_chk(8'h7F, "R10 wrall top", 0);

    // R6: 00 with 10xxxxxx does nothing; disable works with wc low
    xfer(2'b00, 8'h80, 0, 0, 0);
    xfer(2'b01, 8'h08, 16, 64'h0F0F, 0);
    rd_chk(8'h08, "R6 no-op keeps latch", 0);
    wc = 0; xfer(2'b00, 8'h00, 0, 0, 0); wc = 1;
    xfer(2'b01, 8'h08, 16, 64'hF0F0, 0);
    rd_chk(8'h08, "R7 R6 disable with wc low", 0);

    // constrained random mix
    for (int t = 0; t < 180; t++) begin
      kind = $urandom_range(0, 5);
      a = 8'($urandom);
      d = {$urandom, $urandom};
      wc = ($urandom_range(0, 4) != 0);
      psel = ($urandom_range(0, 11) == 0);
      pclr = ($urandom_range(0, 3) == 0);
      bound = 8'($urandom_range(0, 128));
      case (kind)
        0: rd_chk(a, "R3 random read", $urandom_range(0, 2));
        1: begin
          nb = ($urandom_range(0, 7) == 0) ? 15 : 16;
          xfer(2'b01, a, nb, d, 0);
        end
        2: begin
          nb = ($urandom_range(0, 7) == 0) ? 63 : 64;
          xfer(2'b11, a, nb, d, 0);
        end
        3: xfer(2'b00, {2'b01, a[5:0]}, 16, d, 0);
        4: xfer(2'b00, {2'b11, a[5:0]}, 0, 0, $urandom_range(0, 2));
        default: xfer(2'b00, {2'b00, a[5:0]}, 0, 0, 0);
      endcase
    end
    psel = 0;
    for (int k = 0; k < 128; k += 9) rd_chk(8'(k), "R8 R9 R10 final sweep", 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule